// File: doc/BRIEF.md
# CAN Fault Confinement Controller

This block keeps the two CAN error counters for one node and decides, from their values, which of three fault confinement states the node occupies: error active, error passive or bus-off. The protocol engine feeds it one-cycle strobes for transmit errors, receive errors, receiver-side dominant errors that follow an error flag, and successful transmissions and receptions. The block returns both counter values, the current state, a bus-off flag, an enable that permits the node to take part in traffic, and a one-cycle interrupt pulse whenever the state changes.

Once the node is in bus-off, the block watches the sampled receive line for the return sequence: 128 groups of 11 consecutive recessive bits. A configuration bit chooses how the watch begins. In automatic mode, counting starts as soon as bus-off is entered. In manual mode, software must first raise the initialization request and then drop it. Bits that arrive while the initialization request is high are never counted. When the sequence completes, both counters are cleared and the node is error active again.

Top module: `can_fault_conf`

## Requirements
- R1: After reset both counters are 0, `state_o` is 0 (error active), `bus_off_o` is 0, `node_en_o` is 1 and `state_irq_o` is 0.
- R2: The transmit counter rises by 8 on `tx_err_i` and falls by 1 on `tx_ok_i`, never going below 0. When both strobes arrive in the same cycle, the error wins.
- R3: The receive counter rises by 8 on `rx_dom_err_i` (this takes precedence), otherwise by 1 on `rx_err_i`, otherwise falls by 1 on `rx_ok_i`. It stays within 0 to 255.
- R4: `state_o` is 0 (error active) while both counters are below 128. It is 1 (error passive) while either counter is 128 or more, and it returns to 0 as soon as both drop below 128.
- R5: When the transmit counter reaches 256 or more, `state_o` becomes 2 (bus-off), `bus_off_o` becomes 1 and `node_en_o` becomes 0.
- R6: While in bus-off, all error and success strobes are ignored, and both counters hold their values.
- R7: Recovery completes on the 11th consecutive recessive bit (`rx_bit_i`=1 with `bit_vld_i`=1) of the 128th group. A dominant bit discards the partly counted group. On completion, both counters become 0 and `state_o` becomes 0.
- R8: With `auto_rec_i`=1, recessive bits count toward recovery from the first bit after bus-off is entered.
- R9: With `auto_rec_i`=0, recessive bits are not counted until `init_req_i` has been high and then low during bus-off.
- R10: Bits that arrive while `init_req_i` is high are not counted. Counting resumes from the same position once the request drops.
- R11: `state_irq_o` is high for exactly the one cycle in which a new state first appears on `state_o`, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_err_i | input | 1 | Transmit error strobe |
| tx_ok_i | input | 1 | Successful transmission strobe |
| rx_err_i | input | 1 | Receive error strobe |
| rx_dom_err_i | input | 1 | Dominant bit seen by the receiver after an error flag |
| rx_ok_i | input | 1 | Successful reception strobe |
| rx_bit_i | input | 1 | Sampled receive line, 1 = recessive |
| bit_vld_i | input | 1 | Qualifies `rx_bit_i` for one cycle per bit |
| auto_rec_i | input | 1 | 1 = recovery starts automatically |
| init_req_i | input | 1 | Initialization mode request |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| state_o | output | 2 | 0 active, 1 passive, 2 bus-off |
| bus_off_o | output | 1 | High in bus-off |
| node_en_o | output | 1 | High when the node may transmit and receive |
| state_irq_o | output | 1 | One-cycle pulse on a state change |

## Verification
A strobe or bit sampled at clock edge k shows up in the counters, the state, the flags and the interrupt pulse right after edge k. All of these outputs are registers that load at that same edge. The bench drives inputs just after a falling edge and samples outputs at the following falling edge, which is half a cycle after the edge that loaded them. Every result is therefore checked in the one cycle in which it is due. The interrupt pulse is checked to be high in that cycle and low one cycle later. Recovery is checked at the bit just before the finishing bit and then at the finishing bit itself, so an off-by-one in the run length or the group count is caught.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_t;
endpackage

// File: rtl/fc_tx_counter.sv
module fc_tx_counter #(
  parameter int W   = 9,
  parameter int INC = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         hold,
  input  logic         err,
  input  logic         ok,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] INCV = W'(INC);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (hold)
      cnt_d = cnt_q;
    else if (err)
      cnt_d = (cnt_q > MAXV - INCV) ? MAXV : cnt_q + INCV;
    else if (ok && cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R2
  tec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !hold && err && cnt_q <= MAXV - INCV) |=> cnt_q == $past(cnt_q) + INCV);

  // R2
  tec_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !hold && !err && ok && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/fc_rx_counter.sv
module fc_rx_counter #(
  parameter int W       = 8,
  parameter int INC_BIG = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         hold,
  input  logic         err,
  input  logic         dom_err,
  input  logic         ok,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] BIGV = W'(INC_BIG);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (hold)
      cnt_d = cnt_q;
    else if (dom_err)
      cnt_d = (cnt_q > MAXV - BIGV) ? MAXV : cnt_q + BIGV;
    else if (err)
      cnt_d = (cnt_q == MAXV) ? MAXV : cnt_q + 1'b1;
    else if (ok && cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R3
  rec_no_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !ok) |=> cnt_q >= $past(cnt_q));

  // R3
  rec_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt_q == MAXV && !ok) |=> cnt_q == MAXV);
endmodule

// File: rtl/fc_recovery_mon.sv
module fc_recovery_mon #(
  parameter int RUN_LEN = 11,
  parameter int GRP_NUM = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic in_busoff,
  input  logic busoff_entry,
  input  logic auto_rec,
  input  logic init_req,
  input  logic bit_vld,
  input  logic rx_bit,
  output logic done
);
  localparam int RUN_W = $clog2(RUN_LEN);
  localparam int GRP_W = $clog2(GRP_NUM);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GRP_NUM - 1);

  logic [RUN_W-1:0] run_q;
  logic [GRP_W-1:0] grp_q;
  logic             saw_init_q;
  logic             counting;

  assign counting = in_busoff && !init_req && (auto_rec || saw_init_q);
  assign done     = counting && bit_vld && rx_bit &&
                    run_q == RUN_LAST && grp_q == GRP_LAST;

  always_ff @(posedge clk) begin
    if (rst || !in_busoff || busoff_entry) begin
      run_q      <= '0;
      grp_q      <= '0;
      saw_init_q <= 1'b0;
    end else begin
      if (init_req) saw_init_q <= 1'b1;
      if (counting && bit_vld) begin
        if (!rx_bit) begin
          run_q <= '0;
        end else if (run_q == RUN_LAST) begin
          run_q <= '0;
          grp_q <= grp_q + 1'b1;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end

  // R7
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_LAST);

  // R10
  init_pause_chk: assert property (@(posedge clk) disable iff (rst)
    (init_req && in_busoff && !busoff_entry) |=> $stable(run_q) && $stable(grp_q));

  // R7
  dom_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (counting && bit_vld && !rx_bit) |=> run_q == '0);
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int ERR_STEP    = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256,
  parameter int RUN_LEN     = 11,
  parameter int GRP_NUM     = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_err_i,
  input  logic             rx_dom_err_i,
  input  logic             rx_ok_i,
  input  logic             rx_bit_i,
  input  logic             bit_vld_i,
  input  logic             auto_rec_i,
  input  logic             init_req_i,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o,
  output logic [1:0]       state_o,
  output logic             bus_off_o,
  output logic             node_en_o,
  output logic             state_irq_o
);
  localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] TEC_OFF  = TEC_W'(BUSOFF_LIM);
  localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASSIVE_LIM);

  fc_state_t        state_q, state_d;
  logic [TEC_W-1:0] tec_q, tec_d;
  logic [REC_W-1:0] rec_q, rec_d;
  logic             in_busoff, entry, rec_done;
  logic             irq_q, boff_q, en_q;

  assign in_busoff = (state_q == FC_BUSOFF);

  fc_tx_counter #(.W(TEC_W), .INC(ERR_STEP)) u_tec (
    .clk(clk), .rst(rst), .clr(rec_done), .hold(in_busoff),
    .err(tx_err_i), .ok(tx_ok_i), .cnt_q(tec_q), .cnt_d(tec_d)
  );

  fc_rx_counter #(.W(REC_W), .INC_BIG(ERR_STEP)) u_rec (
    .clk(clk), .rst(rst), .clr(rec_done), .hold(in_busoff),
    .err(rx_err_i), .dom_err(rx_dom_err_i), .ok(rx_ok_i),
    .cnt_q(rec_q), .cnt_d(rec_d)
  );

  fc_recovery_mon #(.RUN_LEN(RUN_LEN), .GRP_NUM(GRP_NUM)) u_mon (
    .clk(clk), .rst(rst), .in_busoff(in_busoff), .busoff_entry(entry),
    .auto_rec(auto_rec_i), .init_req(init_req_i), .bit_vld(bit_vld_i),
    .rx_bit(rx_bit_i), .done(rec_done)
  );

  always_comb begin
    if (in_busoff)
      state_d = rec_done ? FC_ACTIVE : FC_BUSOFF;
    else if (tec_d >= TEC_OFF)
      state_d = FC_BUSOFF;
    else if (tec_d >= TEC_PASS || rec_d >= REC_PASS)
      state_d = FC_PASSIVE;
    else
      state_d = FC_ACTIVE;
  end

  assign entry = !in_busoff && (state_d == FC_BUSOFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FC_ACTIVE;
      irq_q   <= 1'b0;
      boff_q  <= 1'b0;
      en_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      irq_q   <= (state_d != state_q);
      boff_q  <= (state_d == FC_BUSOFF);
      en_q    <= (state_d != FC_BUSOFF);
    end
  end

  assign tec_o       = tec_q;
  assign rec_o       = rec_q;
  assign state_o     = state_q;
  assign bus_off_o   = boff_q;
  assign node_en_o   = en_q;
  assign state_irq_o = irq_q;

  // R5
  busoff_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2) |-> (bus_off_o && !node_en_o));

  // R6
  busoff_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_busoff && !rec_done) |=> ($stable(tec_o) && $stable(rec_o)));

  // R11
  irq_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    (state_d != state_q) |=> state_irq_o);

  // R7
  recovery_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rec_done |=> (tec_o == '0 && rec_o == '0 && state_o == 2'd0));
endmodule

// File: tb/tb_can_fault_conf.sv
module tb_can_fault_conf;
  logic clk = 1'b0;
  logic rst;
  logic tx_err, tx_ok, rx_err, rx_dom, rx_ok, rx_bit, bit_vld, auto_rec, init_req;
  logic [8:0] tec;
  logic [7:0] rec;
  logic [1:0] state;
  logic bus_off, node_en, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  can_fault_conf dut (
    .clk(clk), .rst(rst), .tx_err_i(tx_err), .tx_ok_i(tx_ok),
    .rx_err_i(rx_err), .rx_dom_err_i(rx_dom), .rx_ok_i(rx_ok),
    .rx_bit_i(rx_bit), .bit_vld_i(bit_vld), .auto_rec_i(auto_rec),
    .init_req_i(init_req), .tec_o(tec), .rec_o(rec), .state_o(state),
    .bus_off_o(bus_off), .node_en_o(node_en), .state_irq_o(irq)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic strobe(input logic te, input logic to, input logic re,
                        input logic rd, input logic ro);
    tx_err = te; tx_ok = to; rx_err = re; rx_dom = rd; rx_ok = ro;
    @(negedge clk);
    tx_err = 0; tx_ok = 0; rx_err = 0; rx_dom = 0; rx_ok = 0;
  endtask

  task automatic repeat_strobe(input int n, input logic te, input logic to,
                               input logic re, input logic rd, input logic ro);
    for (int i = 0; i < n; i++) strobe(te, to, re, rd, ro);
  endtask

  task automatic send_bits(input int n, input logic v);
    for (int i = 0; i < n; i++) begin
      rx_bit = v; bit_vld = 1'b1;
      @(negedge clk);
    end
    bit_vld = 1'b0; rx_bit = 1'b1;
  endtask

  task automatic t_reset;
    check("R1 tec", tec, 0);
    check("R1 rec", rec, 0);
    check("R1 state", state, 0);
    check("R1 node_en", node_en, 1);
    check("R1 bus_off", bus_off, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_tec;
    repeat_strobe(3, 1, 0, 0, 0, 0);
    check("R2 tec +8x3", tec, 24);
    check("R11 no irq without change", irq, 0);
    strobe(0, 1, 0, 0, 0);
    check("R2 tec -1", tec, 23);
    strobe(1, 1, 0, 0, 0);
    check("R2 tec err wins", tec, 31);
    repeat_strobe(40, 0, 1, 0, 0, 0);
    check("R2 tec floor", tec, 0);
  endtask

  task automatic t_rec;
    repeat_strobe(2, 0, 0, 1, 0, 0);
    check("R3 rec +1x2", rec, 2);
    strobe(0, 0, 0, 1, 0);
    check("R3 rec +8", rec, 10);
    strobe(0, 0, 1, 1, 0);
    check("R3 rec dom wins", rec, 18);
    repeat_strobe(20, 0, 0, 0, 0, 1);
    check("R3 rec floor", rec, 0);
    repeat_strobe(15, 0, 0, 0, 1, 0);
    check("R4 rec 120 active", state, 0);
    strobe(0, 0, 0, 1, 0);
    check("R4 rec 128 passive", state, 1);
    check("R11 irq to passive", irq, 1);
    @(negedge clk);
    check("R11 irq one cycle", irq, 0);
    repeat_strobe(16, 0, 0, 0, 1, 0);
    check("R3 rec ceiling", rec, 255);
    repeat_strobe(127, 0, 0, 0, 0, 1);
    check("R4 rec 128 still passive", state, 1);
    strobe(0, 0, 0, 0, 1);
    check("R4 rec 127 back active", state, 0);
    check("R11 irq to active", irq, 1);
    repeat_strobe(127, 0, 0, 0, 0, 1);
    check("R3 rec back to 0", rec, 0);
  endtask

  task automatic enter_busoff;
    repeat_strobe(15, 1, 0, 0, 0, 0);
    check("R4 tec 120 active", state, 0);
    strobe(1, 0, 0, 0, 0);
    check("R4 tec 128 passive", state, 1);
    repeat_strobe(15, 1, 0, 0, 0, 0);
    check("R4 tec 248 passive", state, 1);
    check("R5 not off at 248", bus_off, 0);
    strobe(1, 0, 0, 0, 0);
    check("R5 state busoff", state, 2);
    check("R5 bus_off flag", bus_off, 1);
    check("R5 node_en low", node_en, 0);
    check("R11 irq to busoff", irq, 1);
    check("R5 tec 256", tec, 256);
  endtask

  task automatic t_auto_recovery;
    auto_rec = 1'b1;
    enter_busoff();
    strobe(1, 1, 1, 1, 1);
    check("R6 tec held", tec, 256);
    check("R6 rec held", rec, 0);
    strobe(0, 1, 0, 0, 1);
    check("R6 tec held after ok", tec, 256);
    send_bits(10, 1'b1);
    send_bits(1, 1'b0);
    send_bits(550, 1'b1);
    init_req = 1'b1;
    send_bits(300, 1'b1);
    init_req = 1'b0;
    send_bits(857, 1'b1);
    check("R10 paused bits not counted", state, 2);
    check("R7 partial group discarded", bus_off, 1);
    send_bits(1, 1'b1);
    check("R8 auto recovery done", state, 0);
    check("R7 tec cleared", tec, 0);
    check("R7 rec cleared", rec, 0);
    check("R7 node_en restored", node_en, 1);
    check("R11 irq on recovery", irq, 1);
    @(negedge clk);
    check("R11 irq dropped", irq, 0);
  endtask

  task automatic t_manual_recovery;
    auto_rec = 1'b0;
    enter_busoff();
    send_bits(1408, 1'b1);
    check("R9 no count before init", state, 2);
    init_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    init_req = 1'b0;
    send_bits(1407, 1'b1);
    check("R9 one bit short", state, 2);
    send_bits(1, 1'b1);
    check("R9 manual recovery done", state, 0);
    check("R9 tec cleared", tec, 0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d cycles", wd, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    tx_err = 0; tx_ok = 0; rx_err = 0; rx_dom = 0; rx_ok = 0;
    rx_bit = 1'b1; bit_vld = 1'b0; auto_rec = 1'b1; init_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tec();
    t_rec();
    t_auto_recovery();
    t_manual_recovery();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule